// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target has left hung, typically with SDA held low part-way through a byte. On a start request it puts the attached bus controller into reset and keeps it there for the whole sequence. It then tests whether both SCL and SDA read high. If they do not, it leaves both lines released and clocks SCL by itself. Each clock is a fixed-width low pulse followed by an equal released gap. The loop stops as soon as both lines read high, or after a configured number of pulses.

Whatever the outcome, the sequence ends in one cycle that lifts the controller reset, strobes the controller's reinitialise input and signals completion. A status flag records whether the bus was free at the last test. The pulse width comes from the clock frequency and a width in nanoseconds, both given as parameters. The block never drives SDA, never forms a STOP condition and reads no register state.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset every output is low: no line driven, controller reset off, done, reinitialise and recovered all 0.
- R2: A start sampled while idle raises `ctrl_reset_o` in the next cycle. It stays high through every cycle of the sequence and is low in the done cycle.
- R3: The bus counts as free only when `scl_i` and `sda_i` are both 1 at a freedom test. A test that finds the bus free issues no further SCL pulse. With a free bus at the first test, `done_o` appears 2 cycles after the start was sampled.
- R4: Each SCL pulse drives `scl_drive_low_o` high for exactly P cycles. P = ceil(CLK_HZ * PULSE_NS / 1e9), with a minimum of 1.
- R5: After each pulse SCL stays released for P cycles, and the next freedom test takes 1 more cycle. One iteration therefore lasts 2P+1 cycles.
- R6: If the bus becomes free after K pulses with K <= MAX_PULSES, exactly K pulses are issued and `recovered_o` is 1.
- R7: If the bus is still not free after MAX_PULSES pulses, the sequence ends without another pulse and `recovered_o` is 0. An SCL line stuck low is handled the same way.
- R8: `done_o` and `reinit_o` are high together for exactly one cycle, 2 + N*(2P+1) cycles after the start was sampled, where N is the number of pulses.
- R9: `recovered_o` takes its new value in the done cycle and holds it until the next done cycle.
- R10: `sda_drive_low_o` is never asserted.
- R11: A start while a sequence is running is ignored. The running sequence keeps its length and produces one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a recovery sequence (taken only when idle) |
| scl_i | input | 1 | Sampled SCL line level, synchronous to clk |
| sda_i | input | 1 | Sampled SDA line level, synchronous to clk |
| scl_drive_low_o | output | 1 | 1 pulls SCL low |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (held 0) |
| ctrl_reset_o | output | 1 | Holds the attached controller in reset |
| reinit_o | output | 1 | One-cycle reinitialise strobe to the controller |
| done_o | output | 1 | One-cycle completion pulse |
| recovered_o | output | 1 | Bus was free at the final test |

## Verification
Every result is due at a cycle offset that can be computed from the start sample. The reset output rises one cycle after the start. Pulse k begins at cycle 2 + (k-1)(2P+1). Done, reinitialise and the status appear at cycle 2 + N(2P+1). The bench counts falling clock edges from the start sample and sees each output one half-period after the edge that sets it. It compares the done cycle, every low run and every released run between pulses against these formulas. The sweep runs the number of needed pulses from zero to beyond the limit, and a busy-time start must leave the done cycle unchanged.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_LOW   = 3'd2,
    ST_GAP   = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  // Pulse length in clock cycles, rounded up, at least one cycle.
  function automatic int unsigned pulse_cycles(input longint unsigned clk_hz,
                                               input longint unsigned width_ns);
    longint unsigned raw;
    raw = (clk_hz * width_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (raw == 0) raw = 1;
    return int'(raw);
  endfunction

endpackage

// File: rtl/unstick_rst_sync.sv
module unstick_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int unsigned LOAD_CYC = 4,
  parameter int unsigned TW       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (en_i & (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i)    cnt_d = TW'(LOAD_CYC - 1);
    else if (en_i) cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_LOAD_NONZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && LOAD_CYC > 1) |=> !zero_o); // R4

endmodule

// File: rtl/unstick_iter.sv
module unstick_iter #(
  parameter int unsigned MAX_PULSES = 100,
  parameter int unsigned IW         = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  output logic at_max_o
);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i | inc_i;
    cnt_d  = clear_i ? '0 : cnt_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_max_o = (cnt_q == IW'(MAX_PULSES));

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IW'(MAX_PULSES)); // R7

endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import i2c_unstick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tmr_zero_i,
  input  logic at_max_i,
  output logic tmr_load_o,
  output logic tmr_en_o,
  output logic iter_clear_o,
  output logic iter_inc_o,
  output logic scl_drive_low_o,
  output logic ctrl_reset_o,
  output logic done_o,
  output logic recovered_o
);

  seq_state_t st_q, st_d;
  logic       rec_q, rec_d, rec_en;
  logic       bus_free;

  assign bus_free = scl_i & sda_i;

  always_comb begin
    st_d         = st_q;
    tmr_load_o   = 1'b0;
    iter_clear_o = 1'b0;
    iter_inc_o   = 1'b0;
    rec_en       = 1'b0;
    rec_d        = rec_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d         = ST_CHECK;
          iter_clear_o = 1'b1;
        end
      end
      ST_CHECK: begin
        if (bus_free || at_max_i) begin
          st_d   = ST_DONE;
          rec_en = 1'b1;
          rec_d  = bus_free;
        end else begin
          st_d       = ST_LOW;
          tmr_load_o = 1'b1;
          iter_inc_o = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_zero_i) begin
          st_d       = ST_GAP;
          tmr_load_o = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_zero_i) st_d = ST_CHECK;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= 1'b0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign tmr_en_o        = (st_q == ST_LOW) || (st_q == ST_GAP);
  assign scl_drive_low_o = (st_q == ST_LOW);
  assign ctrl_reset_o    = (st_q == ST_CHECK) || (st_q == ST_LOW) || (st_q == ST_GAP);
  assign done_o          = (st_q == ST_DONE);
  assign recovered_o     = rec_q;

  AST_FREE_STOPS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && scl_i && sda_i) |=> (done_o && !scl_drive_low_o)); // R3
  AST_RESET_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_reset_o) |-> done_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_CHECK) |=> $stable(recovered_o)); // R9
  AST_PULSE_AFTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low_o) |-> ($past(st_q) == ST_CHECK)); // R5

endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned PULSE_NS   = 10_000,
  parameter int unsigned MAX_PULSES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_low_o,
  output logic sda_drive_low_o,
  output logic ctrl_reset_o,
  output logic reinit_o,
  output logic done_o,
  output logic recovered_o
);

  localparam int unsigned PULSE_CYC =
    i2c_unstick_pkg::pulse_cycles(longint'(CLK_HZ), longint'(PULSE_NS));
  localparam int unsigned TW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam int unsigned IW = $clog2(MAX_PULSES + 1) > 0 ? $clog2(MAX_PULSES + 1) : 1;

  logic rst_sync_n;
  logic tmr_load, tmr_en, tmr_zero;
  logic iter_clear, iter_inc, at_max;
  logic done;

  unstick_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  unstick_timer #(.LOAD_CYC(PULSE_CYC), .TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (tmr_load),
    .en_i   (tmr_en),
    .zero_o (tmr_zero)
  );

  unstick_iter #(.MAX_PULSES(MAX_PULSES), .IW(IW)) u_iter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear_i  (iter_clear),
    .inc_i    (iter_inc),
    .at_max_o (at_max)
  );

  unstick_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .start_i         (start_i),
    .scl_i           (scl_i),
    .sda_i           (sda_i),
    .tmr_zero_i      (tmr_zero),
    .at_max_i        (at_max),
    .tmr_load_o      (tmr_load),
    .tmr_en_o        (tmr_en),
    .iter_clear_o    (iter_clear),
    .iter_inc_o      (iter_inc),
    .scl_drive_low_o (scl_drive_low_o),
    .ctrl_reset_o    (ctrl_reset_o),
    .done_o          (done),
    .recovered_o     (recovered_o)
  );

  assign sda_drive_low_o = 1'b0; // R10: SDA is only ever released
  assign done_o          = done;
  assign reinit_o        = done;

  AST_NO_PULSE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (!scl_drive_low_o && !ctrl_reset_o)); // R8

endmodule

// File: tb/i2c_unstick_seq_test.sv
`timescale 1ns/1ps
module i2c_unstick_seq_test;

  localparam int unsigned CLK_HZ = 125_000_000;
  localparam int unsigned PNS    = 40;
  localparam int unsigned MAXP   = 4;
  localparam int P = int'((longint'(CLK_HZ) * longint'(PNS) + 64'd999_999_999) / 64'd1_000_000_000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_stuck = 1'b0;
  int   need_rel = 0;
  int   rel_cnt = 0;
  int   rel_base = 0;
  int   total = 0;
  int   bad = 0;
  int   wd = 0;

  logic scl_drv, sda_drv, crst, reinit, done, rec;
  logic scl_line, sda_line;

  always #4 clk = ~clk;

  assign scl_line = !scl_drv && !scl_stuck;
  assign sda_line = !sda_drv && ((rel_cnt - rel_base) >= need_rel);

  always @(posedge scl_line) rel_cnt = rel_cnt + 1;

  i2c_unstick_seq #(.CLK_HZ(CLK_HZ), .PULSE_NS(PNS), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv), .ctrl_reset_o(crst),
    .reinit_o(reinit), .done_o(done), .recovered_o(rec));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // One sequence; K releases needed, optional stuck SCL, optional start while busy.
  task automatic run_case(input int k, input bit stuck, input bit poke);
    int cyc = 0, pulses = 0, lowlen = 0, gaplen = 0;
    int bad_low = 0, bad_gap = 0, bad_rst = 0, sda_seen = 0, dones = 0;
    int exp_n, exp_cyc, done_cyc = -1;
    bit prev = 0, exp_rec;
    @(negedge clk);
    scl_stuck = stuck;
    #1;
    rel_base = rel_cnt;
    need_rel = k;
    exp_n   = stuck ? MAXP : ((k <= MAXP) ? k : MAXP);
    exp_rec = !stuck && (k <= MAXP);
    exp_cyc = 2 + exp_n * (2 * P + 1);
    start = 1'b1;
    while (done_cyc < 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (poke && (cyc == 3 || cyc == P + 2)) ? 1'b1 : 1'b0;
      if (sda_drv) sda_seen++;
      if (done) begin
        done_cyc = cyc; dones++;
        if (crst) bad_rst++;
        check(reinit == 1'b1, "R8 reinit with done", reinit, 1);
        check(rec == exp_rec, "R6/R7/R9 recovered", rec, exp_rec);
      end else if (!crst) bad_rst++;
      if (scl_drv && !prev) begin
        pulses++;
        if (pulses > 1 && gaplen != P + 1) bad_gap++;
        lowlen = 1;
      end else if (scl_drv) lowlen++;
      else if (!scl_drv && prev) begin
        if (lowlen != P) bad_low++;
        gaplen = 1;
      end else gaplen++;
      prev = scl_drv;
    end
    start = 1'b0;
    check(done_cyc == exp_cyc, "R3/R5/R8 done cycle", done_cyc, exp_cyc);
    check(pulses == exp_n, stuck ? "R7 pulse count scl stuck" : "R6/R7 pulse count", pulses, exp_n);
    check(bad_low == 0, "R4 low width", bad_low, 0);
    check(bad_gap == 0, "R5 released gap", bad_gap, 0);
    check(bad_rst == 0, "R2 controller reset window", bad_rst, 0);
    check(sda_seen == 0, "R10 sda never driven", sda_seen, 0);
    // After done: single pulse, status held, no activity
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done || scl_drv || crst) dones += 10;
      if (rec != exp_rec) dones += 100;
    end
    check(dones == 1, poke ? "R11 busy start ignored" : "R8/R9 single done, status held", dones, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({scl_drv, sda_drv, crst, reinit, done, rec} == 6'b0, "R1 reset state",
          {scl_drv, sda_drv, crst, reinit, done, rec}, 0);
    for (int k = 0; k <= MAXP + 2; k++) run_case(k, 1'b0, 1'b0);
    run_case(0, 1'b1, 1'b0);
    run_case(2, 1'b0, 1'b1);
    run_case(MAXP, 1'b0, 1'b1);
    run_case(0, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule